// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer. Software drives it through a small register bus and must keep it serviced. A counter climbs from a programmed start value on a slow timebase tick. An optional power-of-two prescaler can stretch that tick. If the count rolls over past its all-ones value, the block emits a one-cycle reset request and starts again from the start value. Software prevents this by writing a new value to the service register, which restarts the count.

Register writes are posted. Each write is held in a staging register and takes effect on the next timebase tick. While it waits, a per-register busy flag is visible in the status word. Arming and disarming the timer each take a two-word key handshake on the key register. The prescaler setting and the start value are frozen while the timer runs. Writes to them in that state complete but change nothing.

Register addresses: 0 prescale control, 1 start value, 2 service, 3 key (reads bit 0 = running), 4 busy status, 5 current count. Unused addresses read as zero.

Top module: `wdt_seqlock`

## Requirements
- R1: After reset the timer is stopped. Every readable register reads zero, and the reset request output is low.
- R2: A bus write to address 0, 1, 2 or 3 sets busy bit 0, 1, 2 or 3 of the status word (address 4) on the next clock. The bit clears on the clock edge of the next tick, and the written value takes effect at that same edge. With nothing staged, the status word reads zero.
- R3: A write to a register whose busy bit is set is discarded. The staged value is kept.
- R4: Applied key writes 0xBBBB followed directly by 0x4444 start the timer. The key register then reads 1, and the count is loaded from the start value.
- R5: Applied key writes 0xAAAA followed directly by 0x5555 stop the timer. The same words in the reverse order do not stop it.
- R6: Any key word that is not the expected next word of a sequence discards the partial sequence. 0xBBBB, then another value, then 0x4444 leaves the timer stopped.
- R7: While the timer runs, writes to the prescale control and the start value complete (their busy bits clear) but leave both registers unchanged.
- R8: Prescale control bit 0 enables the prescaler, and bits 4:2 hold the ratio r. With the prescaler enabled, the count advances once per 2^r ticks. With it disabled, the count advances on every tick.
- R9: A service write whose value differs from the last accepted service value reloads the count from the start value. A repeated identical value has no effect.
- R10: When the count advances from all ones, the reset request is high for exactly one clock and the count reloads from the start value.
- R11: While the timer is stopped, the count holds and no reset request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow timebase enable, one clock wide |
| bus_we_i | input | 1 | Write strobe |
| bus_addr_i | input | 3 | Register address for reads and writes |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| wdt_rst_o | output | 1 | Reset request pulse on rollover |

## Verification
The assertions check the following on every cycle:
- busy flags rise only after a write to the matching address, and fall on the next tick;
- the configuration stays frozen whenever the timer runs;
- the count changes only on a tick;
- a stopped timer neither moves nor requests reset;
- every reset request lasts a single clock.

Only the bench scenarios can show the rest: that the key handshakes accept the right word orders and reject broken ones, that the prescaler ratios give the right step counts, that a repeated service value is ignored, and that rollover reloads the exact start value.

// File: rtl/wdt_seqlock_pkg.sv
package wdt_seqlock_pkg;

  localparam int NUM_TGT = 4;

  localparam int TGT_CTRL = 0;
  localparam int TGT_LOAD = 1;
  localparam int TGT_TRIG = 2;
  localparam int TGT_KEY  = 3;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_LOAD = 3'd1;
  localparam logic [2:0] ADDR_TRIG = 3'd2;
  localparam logic [2:0] ADDR_KEY  = 3'd3;
  localparam logic [2:0] ADDR_STAT = 3'd4;
  localparam logic [2:0] ADDR_CNT  = 3'd5;

  localparam logic [15:0] KEY_ARM_A = 16'hBBBB;
  localparam logic [15:0] KEY_ARM_B = 16'h4444;
  localparam logic [15:0] KEY_DIS_A = 16'hAAAA;
  localparam logic [15:0] KEY_DIS_B = 16'h5555;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ARM  = 2'd1,
    SEQ_DIS  = 2'd2
  } seq_e;

  // Last divider phase before a count step, for a ratio r: 2^r - 1.
  function automatic int unsigned pre_terminal(input int unsigned ratio);
    return (32'd1 << ratio) - 32'd1;
  endfunction

endpackage

// File: rtl/wdt_regport.sv
module wdt_regport #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int NUM_TGT = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tick,
  input  logic                           bus_we,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [NUM_TGT-1:0]             pend,
  output logic [NUM_TGT-1:0]             apply,
  output logic [NUM_TGT-1:0][DATA_W-1:0] hold
);

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
    logic              hit;
    logic              pend_q;
    logic [DATA_W-1:0] hold_q;

    assign hit      = bus_we && (bus_addr == ADDR_W'(i));
    assign apply[i] = tick && pend_q;
    assign pend[i]  = pend_q;
    assign hold[i]  = hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        hold_q <= '0;
      end else if (apply[i]) begin
        pend_q <= 1'b0;
      end else if (hit && !pend_q) begin
        pend_q <= 1'b1;
        hold_q <= bus_wdata;
      end
    end
  end

endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_apply,
  input  logic [DATA_W-1:0] key_data,
  output logic              run,
  output logic              start_evt
);
  import wdt_seqlock_pkg::*;

  seq_e state_q;
  logic run_q;
  logic is_arm_a, is_arm_b, is_dis_a, is_dis_b;

  assign is_arm_a = (key_data == DATA_W'(KEY_ARM_A));
  assign is_arm_b = (key_data == DATA_W'(KEY_ARM_B));
  assign is_dis_a = (key_data == DATA_W'(KEY_DIS_A));
  assign is_dis_b = (key_data == DATA_W'(KEY_DIS_B));

  assign start_evt = key_apply && (state_q == SEQ_ARM) && is_arm_b && !run_q;
  assign run       = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      run_q   <= 1'b0;
    end else if (key_apply) begin
      state_q <= SEQ_IDLE;
      if (is_arm_a) begin
        state_q <= SEQ_ARM;
      end else if (is_dis_a) begin
        state_q <= SEQ_DIS;
      end else if (is_arm_b && state_q == SEQ_ARM) begin
        run_q <= 1'b1;
      end else if (is_dis_b && state_q == SEQ_DIS) begin
        run_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W   = 16,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               run,
  input  logic               load_now,
  input  logic [CNT_W-1:0]   load_val,
  input  logic               pre_en,
  input  logic [RATIO_W-1:0] ratio,
  output logic [CNT_W-1:0]   count,
  output logic               step,
  output logic               wrap
);
  localparam int PRE_W = (1 << RATIO_W) - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] term;
  logic [CNT_W-1:0] count_q;
  logic             wrap_q;

  assign term  = PRE_W'(wdt_seqlock_pkg::pre_terminal(32'(ratio)));
  assign step  = !pre_en || (pre_q == term);
  assign count = count_q;
  assign wrap  = wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      pre_q   <= '0;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (load_now) begin
        count_q <= load_val;
        pre_q   <= '0;
      end else if (run && tick) begin
        if (step) begin
          pre_q <= '0;
          if (count_q == CNT_MAX) begin
            count_q <= load_val;
            wrap_q  <= 1'b1;
          end else begin
            count_q <= count_q + 1'b1;
          end
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wdt_seqlock.sv
module wdt_seqlock #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3,
  parameter int CNT_W     = 16,
  parameter int RATIO_W   = 3,
  parameter int RATIO_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              wdt_rst_o
);
  import wdt_seqlock_pkg::*;

  logic [NUM_TGT-1:0]             pend;
  logic [NUM_TGT-1:0]             apply;
  logic [NUM_TGT-1:0][DATA_W-1:0] hold;

  logic               run;
  logic               start_evt;
  logic               reload_evt;
  logic               load_now;
  logic               pre_en_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [CNT_W-1:0]   load_q;
  logic [DATA_W-1:0]  trig_last_q;
  logic [DATA_W-1:0]  ctrl_word;
  logic [CNT_W-1:0]   count;
  logic               step;
  logic               wrap;

  wdt_regport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_TGT(NUM_TGT)) u_regport (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .bus_we   (bus_we_i),
    .bus_addr (bus_addr_i),
    .bus_wdata(bus_wdata_i),
    .pend     (pend),
    .apply    (apply),
    .hold     (hold)
  );

  wdt_keyseq #(.DATA_W(DATA_W)) u_keyseq (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_apply(apply[TGT_KEY]),
    .key_data (hold[TGT_KEY]),
    .run      (run),
    .start_evt(start_evt)
  );

  assign reload_evt = apply[TGT_TRIG] && (hold[TGT_TRIG] != trig_last_q);
  assign load_now   = start_evt || reload_evt;

  // Configuration writes land only while stopped; the busy bit clears regardless.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_en_q    <= 1'b0;
      ratio_q     <= '0;
      load_q      <= '0;
      trig_last_q <= '0;
    end else begin
      if (apply[TGT_CTRL] && !run) begin
        pre_en_q <= hold[TGT_CTRL][0];
        ratio_q  <= hold[TGT_CTRL][RATIO_LSB +: RATIO_W];
      end
      if (apply[TGT_LOAD] && !run) begin
        load_q <= hold[TGT_LOAD][CNT_W-1:0];
      end
      if (reload_evt) begin
        trig_last_q <= hold[TGT_TRIG];
      end
    end
  end

  wdt_counter #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_i),
    .run     (run),
    .load_now(load_now),
    .load_val(load_q),
    .pre_en  (pre_en_q),
    .ratio   (ratio_q),
    .count   (count),
    .step    (step),
    .wrap    (wrap)
  );

  always_comb begin
    ctrl_word                           = '0;
    ctrl_word[0]                        = pre_en_q;
    ctrl_word[RATIO_LSB +: RATIO_W]     = ratio_q;
  end

  always_comb begin
    case (bus_addr_i)
      ADDR_W'(ADDR_CTRL): bus_rdata_o = ctrl_word;
      ADDR_W'(ADDR_LOAD): bus_rdata_o = DATA_W'(load_q);
      ADDR_W'(ADDR_TRIG): bus_rdata_o = trig_last_q;
      ADDR_W'(ADDR_KEY):  bus_rdata_o = DATA_W'(run);
      ADDR_W'(ADDR_STAT): bus_rdata_o = DATA_W'(pend);
      ADDR_W'(ADDR_CNT):  bus_rdata_o = DATA_W'(count);
      default:            bus_rdata_o = '0;
    endcase
  end

  assign wdt_rst_o = wrap;

endmodule

// File: rtl/wdt_seqlock_chk.sv
module wdt_seqlock_chk #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3,
  parameter int CNT_W   = 16,
  parameter int NUM_TGT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [NUM_TGT-1:0] pend,
  input logic [NUM_TGT-1:0] apply,
  input logic               run,
  input logic               start_evt,
  input logic [CNT_W-1:0]   count,
  input logic [CNT_W-1:0]   load,
  input logic [DATA_W-1:0]  ctrl_word,
  input logic               wdt_rst
);
  import wdt_seqlock_pkg::*;

  // R2: a free target captures a write and shows busy next clock
  a_r2_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(ADDR_LOAD) && !pend[TGT_LOAD]) |=> pend[TGT_LOAD]);

  // R2: every busy bit present at a tick is gone after it
  a_r2_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend != '0) |=> ((pend & $past(pend)) == '0));

  // R3: busy only rises after a write to that address
  a_r3_pend_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[TGT_TRIG]) |-> $past(bus_we && bus_addr == ADDR_W'(ADDR_TRIG)));

  // R4: start loads the start value and runs
  a_r4_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (run && count == $past(load)));

  // R7: configuration frozen while running
  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(load) && $stable(ctrl_word)));

  // R8: count moves only on a tick
  a_r8_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  // R10: reset request is a single clock
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);

  // R11: stopped timer raises no request
  a_r11_no_rst_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !wdt_rst);

  // R11: stopped timer holds its count unless serviced or started
  a_r11_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !apply[TGT_TRIG] && !start_evt) |=> $stable(count));

endmodule

bind wdt_seqlock wdt_seqlock_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_TGT(wdt_seqlock_pkg::NUM_TGT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick_i),
  .bus_we   (bus_we_i),
  .bus_addr (bus_addr_i),
  .pend     (pend),
  .apply    (apply),
  .run      (run),
  .start_evt(start_evt),
  .count    (count),
  .load     (load_q),
  .ctrl_word(ctrl_word),
  .wdt_rst  (wdt_rst_o)
);

// File: tb/tb_wdt_seqlock.sv
module tb_wdt_seqlock;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        wrst;

  int checks = 0;
  int errors = 0;
  int rst_seen = 0;

  always #5 clk = ~clk;

  wdt_seqlock dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .wdt_rst_o(wrst)
  );

  // {prescaler enable, ratio, ticks, expected advance}
  localparam int NVEC = 6;
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 5, 5}, '{1, 0, 5, 5}, '{1, 1, 6, 3},
    '{1, 2, 9, 2}, '{1, 3, 16, 2}, '{1, 3, 7, 0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (wrst) rst_seen++;
    end
  endtask

  task automatic start_wdt();
    wr(3'd3, 16'hBBBB); tk(1);
    wr(3'd3, 16'h4444); tk(1);
  endtask

  task automatic stop_wdt();
    wr(3'd3, 16'hAAAA); tk(1);
    wr(3'd3, 16'h5555); tk(1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset readback", v, 16'h0);
    end
    chk("R1 reset output", {15'h0, wrst}, 16'h0);

    // R2 posted write and busy flag
    wr(3'd1, 16'h1234);
    rd(3'd4, v); chk("R2 busy load", v, 16'h0002);
    rd(3'd1, v); chk("R2 not yet applied", v, 16'h0000);
    tk(1);
    rd(3'd4, v); chk("R2 status idle", v, 16'h0000);
    rd(3'd1, v); chk("R2 applied", v, 16'h1234);

    // R3 second write while busy dropped
    wr(3'd1, 16'h0050);
    wr(3'd1, 16'h0060);
    tk(1);
    rd(3'd1, v); chk("R3 dropped write", v, 16'h0050);

    // R6 broken arm sequence
    wr(3'd3, 16'hBBBB); tk(1);
    wr(3'd3, 16'h1111); tk(1);
    wr(3'd3, 16'h4444); tk(1);
    rd(3'd3, v); chk("R6 stays stopped", v, 16'h0000);

    // R8 prescaler vectors (R4 start loads)
    for (int k = 0; k < NVEC; k++) begin
      stop_wdt();
      wr(3'd0, 16'(VEC[k][0] | (VEC[k][1] << 2)));
      wr(3'd1, 16'h0100);
      tk(1);
      rd(3'd0, v); chk("R8 ctrl readback", v, 16'(VEC[k][0] | (VEC[k][1] << 2)));
      start_wdt();
      rd(3'd3, v); chk("R4 running", v, 16'h0001);
      rd(3'd5, v); chk("R4 count loaded", v, 16'h0100);
      tk(VEC[k][2]);
      rd(3'd5, v); chk("R8 advance", v, 16'(16'h0100 + VEC[k][3]));
    end

    // R7 frozen configuration
    stop_wdt();
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0050);
    tk(1);
    start_wdt();
    wr(3'd1, 16'h0077);
    wr(3'd0, 16'h000D);
    tk(1);
    rd(3'd1, v); chk("R7 load frozen", v, 16'h0050);
    rd(3'd0, v); chk("R7 ctrl frozen", v, 16'h0000);
    rd(3'd4, v); chk("R7 busy cleared", v, 16'h0000);
    rd(3'd5, v); chk("R7 count", v, 16'h0051);

    // R9 service
    wr(3'd2, 16'h00AB); tk(1);
    rd(3'd5, v); chk("R9 reload", v, 16'h0050);
    tk(3);
    wr(3'd2, 16'h00AB); tk(1);
    rd(3'd5, v); chk("R9 repeat ignored", v, 16'h0054);
    rd(3'd2, v); chk("R9 last value", v, 16'h00AB);

    // R5 reversed order does not stop, proper order does
    wr(3'd3, 16'h5555); tk(1);
    wr(3'd3, 16'hAAAA); tk(1);
    rd(3'd3, v); chk("R5 reversed keeps running", v, 16'h0001);
    stop_wdt();
    rd(3'd3, v); chk("R5 stopped", v, 16'h0000);

    // R11 stopped hold
    rd(3'd5, c0);
    rst_seen = 0;
    tk(5);
    rd(3'd5, v); chk("R11 count holds", v, c0);
    chk("R11 no request", 16'(rst_seen), 16'h0);

    // R10 rollover
    wr(3'd1, 16'hFFFC); tk(1);
    start_wdt();
    rst_seen = 0;
    tk(3);
    rd(3'd5, v); chk("R10 at max", v, 16'hFFFF);
    chk("R10 no early request", 16'(rst_seen), 16'h0);
    tk(1);
    chk("R10 request seen", 16'(rst_seen), 16'h1);
    @(negedge clk);
    chk("R10 single cycle", {15'h0, wrst}, 16'h0);
    rd(3'd5, v); chk("R10 reloaded", v, 16'hFFFC);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule